// File: doc/BRIEF.md
# Stepping Clock Motor Pulse Generator

This block produces the coil drive pulses for a quartz-clock stepping motor, working from a 32768 Hz reference clock. It divides the reference into base ticks (32 per second with default parameters) and counts them. When the count reaches the threshold of the selected speed, it issues one coil pulse of fixed length. Successive pulses alternate between two outputs, so the motor's rotor is pushed in alternating directions as a stepping motor needs.

Two active-low speed switches select either normal time, at one step per second, or one of three faster rates. Each faster rate has its own threshold in base ticks, and the three thresholds are taken from configuration inputs while reset is held. The threshold test is greater-or-equal. So when the speed is switched partway through a count and the count is already past the new threshold, the block steps on the next base tick instead of running on to wrap.

Top module: `motor_pulse_gen`

## Requirements
- R1: A base tick occurs once every `PRESCALE` clock cycles, with the prescaler cleared by reset. In normal mode the first coil output rises on the `32*PRESCALE`-th cycle after reset is released.
- R2: The speed index is formed from the switches as follows. `speed1N` low adds 1 and `speed2N` low adds 2. Index 0 is normal, index 1 uses `fastDiv1`, index 2 uses `fastDiv2` and index 3 uses `fastDiv3`. Both switches pass through a two-flop synchronizer before use.
- R3: In normal mode (index 0), consecutive pulse starts are 32 base ticks apart.
- R4: In fast mode k, consecutive pulse starts are `fastDivk` base ticks apart, for any divider of 1 or more.
- R5: A pulse may only be issued on a base tick, and it is issued when the incremented tick count is greater than or equal to the active threshold. A switch to a faster mode while the count is already past the new threshold therefore produces a pulse on the next base tick after synchronization.
- R6: Every pulse toggles the polarity. The first pulse after reset goes to `coilA`, and pulses then alternate A, B, A, and so on.
- R7: Each pulse holds exactly one output high for `ENERGISE_CYCLES` cycles. At no time are both outputs high.
- R8: The three fast dividers are captured while `rstN` is low. Changes on the divider inputs after reset have no effect on the step period.
- R9: While `rstN` is low, both outputs are low from the first clock edge onward, including when a pulse was in progress.
- R10: When a new pulse fires on the same cycle that the previous pulse's energise time expires, the drive passes directly from one output to the other with no idle cycle, and the new pulse still lasts `ENERGISE_CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (32768 Hz in the target use) |
| rstN | input | 1 | Synchronous active-low reset; also captures the dividers |
| speed1N | input | 1 | Speed switch 1, active low, asynchronous |
| speed2N | input | 1 | Speed switch 2, active low, asynchronous |
| fastDiv1 | input | COUNT_W | Threshold in base ticks for speed index 1 |
| fastDiv2 | input | COUNT_W | Threshold in base ticks for speed index 2 |
| fastDiv3 | input | COUNT_W | Threshold in base ticks for speed index 3 |
| coilA | output | 1 | Coil drive, first polarity |
| coilB | output | 1 | Coil drive, second polarity |

## Verification
Two events can land on the same clock edge: the energise timer of the running pulse reaching its end, and a new pulse firing. This happens when the step interval equals the energise length. The bench provokes it by reloading a divider of 1 with the prescale set equal to the energise length, so a pulse fires on every base tick. It judges the result by observing that the drive moves straight from one coil to the other on that edge, that each side still lasts the full energise length, and that the two outputs are never high together.

// File: rtl/motor_pulse_pkg.sv
package motor_pulse_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0,
    SPD_FAST1  = 2'd1,
    SPD_FAST2  = 2'd2,
    SPD_FAST3  = 2'd3
  } speedIdx_t;

  // strobes issued by the control section to the datapath
  typedef struct packed {
    logic fire;      // issue a coil pulse on this cycle
    logic countHold; // keep the tick count (no base tick this cycle)
  } ctrlStrobe_t;

  localparam int NUM_FAST = 3;
  localparam int NUM_SWITCH = 2;

endpackage

// File: rtl/motor_pulse_sync.sv
module motor_pulse_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  // released switches read high, so reset to ones
  for (genvar g = 0; g < WIDTH; g++) begin : gChan
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], asyncIn[g]};
    end
    assign syncOut[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/motor_pulse_ctrl.sv
module motor_pulse_ctrl
  import motor_pulse_pkg::*;
#(
  parameter int COUNT_W      = 8,
  parameter int NORMAL_TICKS = 32,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               speed1N,
  input  logic               speed2N,
  input  logic [COUNT_W-1:0] fastDiv1,
  input  logic [COUNT_W-1:0] fastDiv2,
  input  logic [COUNT_W-1:0] fastDiv3,
  input  logic               tickStb,
  input  logic [COUNT_W-1:0] nextCount,
  output ctrlStrobe_t        strobe
);

  localparam logic [COUNT_W-1:0] NORMAL_LIMIT = COUNT_W'(NORMAL_TICKS);

  logic [NUM_SWITCH-1:0] swSync;
  speedIdx_t             speedIdx;
  logic [COUNT_W-1:0]    divReg [NUM_FAST];
  logic [COUNT_W-1:0]    divIn  [NUM_FAST];
  logic                  thresholdHit;

  motor_pulse_sync #(
    .WIDTH (NUM_SWITCH),
    .STAGES(SYNC_STAGES)
  ) swSync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({speed2N, speed1N}),
    .syncOut(swSync)
  );

  // switch 1 weighs 1, switch 2 weighs 2; both active low
  assign speedIdx = speedIdx_t'(~swSync);

  assign divIn[0] = fastDiv1;
  assign divIn[1] = fastDiv2;
  assign divIn[2] = fastDiv3;

  // dividers are sampled only while reset is held
  for (genvar g = 0; g < NUM_FAST; g++) begin : gDiv
    always_ff @(posedge clk) begin
      if (!rstN) divReg[g] <= divIn[g];
    end
  end

  always_comb begin
    unique case (speedIdx)
      SPD_NORMAL: thresholdHit = (nextCount >= NORMAL_LIMIT);
      SPD_FAST1:  thresholdHit = (nextCount >= divReg[0]);
      SPD_FAST2:  thresholdHit = (nextCount >= divReg[1]);
      SPD_FAST3:  thresholdHit = (nextCount >= divReg[2]);
      default:    thresholdHit = 1'b0;
    endcase
  end

  assign strobe.fire      = rstN & tickStb & thresholdHit;
  assign strobe.countHold = ~tickStb;

endmodule

// File: rtl/motor_pulse_dp.sv
module motor_pulse_dp
  import motor_pulse_pkg::*;
#(
  parameter int PRESCALE        = 1024,
  parameter int COUNT_W         = 8,
  parameter int ENERGISE_CYCLES = 983
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  output logic               tickStb,
  output logic [COUNT_W-1:0] nextCount,
  output logic               coilA,
  output logic               coilB
);

  localparam int PRE_W   = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam int TIMER_W = (ENERGISE_CYCLES > 2) ? $clog2(ENERGISE_CYCLES) : 1;
  localparam logic [PRE_W-1:0]   PRE_LAST  = PRE_W'(PRESCALE - 1);
  localparam logic [TIMER_W-1:0] TIMER_TOP = TIMER_W'(ENERGISE_CYCLES - 1);
  localparam bit PRE_POW2 = ((PRESCALE & (PRESCALE - 1)) == 0);

  logic [PRE_W-1:0]   preCount;
  logic [COUNT_W-1:0] tickCount;
  logic               polarity;
  logic [TIMER_W-1:0] energiseTimer;
  logic               coilActive;

  // prescaler: a free wrap when the ratio is a power of two, compare otherwise
  if (PRE_POW2) begin : gPrePow2
    assign tickStb = &preCount;
    always_ff @(posedge clk) begin
      if (!rstN) preCount <= '0;
      else       preCount <= preCount + 1'b1;
    end
  end else begin : gPreCmp
    assign tickStb = (preCount == PRE_LAST);
    always_ff @(posedge clk) begin
      if (!rstN)        preCount <= '0;
      else if (tickStb) preCount <= '0;
      else              preCount <= preCount + 1'b1;
    end
  end

  assign nextCount = tickCount + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN)                  tickCount <= '0;
    else if (strobe.fire)       tickCount <= '0;
    else if (!strobe.countHold) tickCount <= nextCount;
  end

  assign coilActive = coilA | coilB;

  // pulse launch and energise timer; a new launch wins over expiry
  always_ff @(posedge clk) begin
    if (!rstN) begin
      polarity      <= 1'b0;
      energiseTimer <= '0;
      coilA         <= 1'b0;
      coilB         <= 1'b0;
    end else if (strobe.fire) begin
      polarity      <= ~polarity;
      energiseTimer <= TIMER_TOP;
      coilA         <= ~polarity;
      coilB         <= polarity;
    end else if (coilActive) begin
      if (energiseTimer == '0) begin
        coilA <= 1'b0;
        coilB <= 1'b0;
      end else begin
        energiseTimer <= energiseTimer - 1'b1;
      end
    end
  end

endmodule

// File: rtl/motor_pulse_gen.sv
module motor_pulse_gen
  import motor_pulse_pkg::*;
#(
  parameter int PRESCALE        = 1024,
  parameter int COUNT_W         = 8,
  parameter int NORMAL_TICKS    = 32,
  parameter int ENERGISE_CYCLES = 983,
  parameter int SYNC_STAGES     = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               speed1N,
  input  logic               speed2N,
  input  logic [COUNT_W-1:0] fastDiv1,
  input  logic [COUNT_W-1:0] fastDiv2,
  input  logic [COUNT_W-1:0] fastDiv3,
  output logic               coilA,
  output logic               coilB
);

  ctrlStrobe_t        strobe;
  logic               tickStb;
  logic [COUNT_W-1:0] nextCount;

  motor_pulse_ctrl #(
    .COUNT_W     (COUNT_W),
    .NORMAL_TICKS(NORMAL_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .speed1N  (speed1N),
    .speed2N  (speed2N),
    .fastDiv1 (fastDiv1),
    .fastDiv2 (fastDiv2),
    .fastDiv3 (fastDiv3),
    .tickStb  (tickStb),
    .nextCount(nextCount),
    .strobe   (strobe)
  );

  motor_pulse_dp #(
    .PRESCALE       (PRESCALE),
    .COUNT_W        (COUNT_W),
    .ENERGISE_CYCLES(ENERGISE_CYCLES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tickStb  (tickStb),
    .nextCount(nextCount),
    .coilA    (coilA),
    .coilB    (coilB)
  );

endmodule

// File: rtl/motor_pulse_gen_chk.sv
module motor_pulse_gen_chk
  import motor_pulse_pkg::*;
#(
  parameter int ENERGISE_CYCLES = 983
) (
  input logic        clk,
  input logic        rstN,
  input ctrlStrobe_t strobe,
  input logic        tickStb,
  input logic        coilA,
  input logic        coilB
);

  localparam int HI_W = $clog2(ENERGISE_CYCLES + 1) + 1;

  logic [HI_W-1:0] highRun;
  logic            expectA;

  always_ff @(posedge clk) begin
    if (!rstN)                highRun <= '0;
    else if (strobe.fire)     highRun <= '0;
    else if (coilA || coilB)  highRun <= highRun + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            expectA <= 1'b1;
    else if (strobe.fire) expectA <= ~expectA;
  end

  assert_single_coil_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(coilA && coilB));

  assert_width_limit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (coilA || coilB) |-> (highRun < HI_W'(ENERGISE_CYCLES)));

  assert_fire_on_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |-> tickStb);

  assert_alternate_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> (coilA == $past(expectA)) && (coilB == !$past(expectA)));

  assert_start_needs_fire_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(coilA) || $rose(coilB)) |-> $past(strobe.fire));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rstN |=> (!coilA && !coilB));

endmodule

bind motor_pulse_gen motor_pulse_gen_chk #(
  .ENERGISE_CYCLES(ENERGISE_CYCLES)
) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .strobe (strobe),
  .tickStb(tickStb),
  .coilA  (coilA),
  .coilB  (coilB)
);

// File: tb/motor_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module motor_pulse_gen_tb_top;

  localparam int PRE = 8;
  localparam int EN  = 8;
  localparam int CW  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic speed1N = 1'b1;
  logic speed2N = 1'b1;
  logic [CW-1:0] fastDiv1 = 8'd3;
  logic [CW-1:0] fastDiv2 = 8'd2;
  logic [CW-1:0] fastDiv3 = 8'd4;
  logic coilA, coilB;

  always #2.5 clk = ~clk;

  motor_pulse_gen #(
    .PRESCALE       (PRE),
    .COUNT_W        (CW),
    .NORMAL_TICKS   (32),
    .ENERGISE_CYCLES(EN),
    .SYNC_STAGES    (2)
  ) dut_i (
    .clk(clk), .rstN(rstN), .speed1N(speed1N), .speed2N(speed2N),
    .fastDiv1(fastDiv1), .fastDiv2(fastDiv2), .fastDiv3(fastDiv3),
    .coilA(coilA), .coilB(coilB)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  // output monitor, sampled on the falling edge
  int cycNow = 0, lastStartCyc = 0, interval = 0, startCnt = 0;
  int prevCode = 0, lastStartCode = 0, prevStartCode = 0, runLen = 0, doneWidth = 0;

  always @(negedge clk) begin
    int code;
    code = coilA ? 1 : (coilB ? 2 : 0);
    cycNow++;
    if (code != prevCode && prevCode != 0) doneWidth = runLen;
    if (code != 0 && code != prevCode) begin
      startCnt++;
      interval      = cycNow - lastStartCyc;
      lastStartCyc  = cycNow;
      prevStartCode = lastStartCode;
      lastStartCode = code;
      runLen        = 1;
    end else if (code != 0) begin
      runLen++;
    end
    prevCode = code;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitStart(input string req);
    int target;
    target = startCnt + 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      if (startCnt >= target) return;
    end
    check(1'b0, {req, " no pulse"}, 0, 1);
  endtask

  task automatic doReset();
    @(negedge clk); #1;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    #1 rstN = 1'b1;
  endtask

  // {speed1N, speed2N, threshold in ticks}
  localparam logic [9:0] VEC [6] = '{
    {1'b1, 1'b1, 8'd32},
    {1'b0, 1'b1, 8'd3},
    {1'b1, 1'b0, 8'd2},
    {1'b0, 1'b0, 8'd4},
    {1'b0, 1'b1, 8'd3},
    {1'b1, 1'b1, 8'd32}
  };

  initial begin
    int n;
    // reset state and first pulse timing (R9, R1, R6)
    repeat (4) @(negedge clk);
    #1 check(!coilA && !coilB, "R9 idle in reset", coilA + coilB, 0);
    @(negedge clk);
    rstN = 1'b1;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); #1;
      n++;
      if (coilA || coilB) break;
    end
    check(n == 32 * PRE, "R1 first pulse delay", n, 32 * PRE);
    check(coilA && !coilB, "R6 first pulse on A", coilA, 1);

    // table of speed codes: period (R2 R3 R4), alternation (R6), width (R7)
    for (int v = 0; v < 6; v++) begin
      speed1N = VEC[v][9];
      speed2N = VEC[v][8];
      waitStart("R2 resync");
      waitStart("R2 period");
      check(interval == int'(VEC[v][7:0]) * PRE,
            (VEC[v][7:0] == 8'd32) ? "R3 normal period" : "R4 fast period",
            interval, int'(VEC[v][7:0]) * PRE);
      check(lastStartCode != prevStartCode, "R6 alternate", lastStartCode, 3 - prevStartCode);
      waitStart("R7 width");
      check(doneWidth == EN, "R7 width", doneWidth, EN);
    end

    // greater-or-equal compare on a mid-count mode change (R5)
    waitStart("R5 align");
    repeat (20 * PRE) @(negedge clk);
    #1 speed1N = 1'b0;
    n = startCnt;
    begin
      int waitCyc = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk); #1;
        waitCyc++;
        if (startCnt != n) break;
      end
      check(waitCyc <= 2 * PRE + 2, "R5 early pulse", waitCyc, 2 * PRE + 2);
    end

    // divider inputs ignored after reset (R8)
    fastDiv1 = 8'd6; fastDiv2 = 8'd6; fastDiv3 = 8'd6;
    waitStart("R8 sync");
    waitStart("R8 period");
    check(interval == 3 * PRE, "R8 divider held", interval, 3 * PRE);

    // reload with divider 1: back-to-back pulses (R10, R8)
    fastDiv1 = 8'd1;
    speed1N = 1'b1;
    doReset();
    speed1N = 1'b0;
    waitStart("R10 sync");
    waitStart("R10 a");
    waitStart("R10 b");
    check(interval == PRE, "R8 reloaded divider", interval, PRE);
    check(lastStartCode != prevStartCode, "R10 direct handover", lastStartCode, 3 - prevStartCode);
    check(doneWidth == EN, "R10 full width", doneWidth, EN);
    check(coilA ^ coilB, "R10 one coil", coilA + coilB, 1);

    // reset in the middle of a pulse (R9)
    speed1N = 1'b1;
    waitStart("R9 pulse");
    #1 rstN = 1'b0;
    @(negedge clk); #1;
    check(!coilA && !coilB, "R9 reset clears pulse", coilA + coilB, 0);
    rstN = 1'b1;

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule